// File: doc/BRIEF.md
# In-Order Pipeline Hazard Scheduler

This block places a stream of instruction descriptors on the timeline of a three-stage in-order pipeline that has no forwarding. Each descriptor names one destination register and up to two source registers, and each source has its own enable. For every instruction the block returns the cycles of its fetch, decode and execute stages. It keeps a table of the last writer of each register. When a source was written earlier in the same program, the consumer's execute stage moves to at least two cycles after its producer's execute stage. Otherwise the instruction executes one cycle after the one before it.

The block closes a program in one of two ways. The last instruction can carry an end flag, or a separate end-only descriptor can follow the last instruction. When a program closes, the block reports the total cycle count and clears the writer table, so the next program starts fresh. A safety monitor watches the emitted schedule and raises a sticky error if any consumer decodes at or before its producer's execute cycle.

Both streams use valid/ready. A descriptor is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only while a result sits in the single output slot and `out_ready` is low. A held result keeps all its output values unchanged until `out_ready` takes it. The done report travels in the same output slot and is released by the same `out_ready`.

Top module: `hazard_sched`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, and `out_valid`, `done_valid` and `sched_err` are 0.
- R2: The first instruction of a program executes at cycle 2, decodes at cycle 1 and fetches at cycle 0.
- R3: For every instruction, `out_fetch` equals `out_exec` minus 2 and `out_decode` equals `out_exec` minus 1.
- R4: An instruction whose enabled sources have no producer in the current program executes exactly one cycle after the previous instruction.
- R5: If an enabled source has a producer, the execute cycle is the larger of the previous execute plus 1 and the producer's execute plus 2. A source whose enable bit is 0 has no effect.
- R6: The producer of a register is the most recent earlier instruction that named it as destination. An instruction that reads its own destination sees the earlier writer, not itself.
- R7: When a program closes, `done_valid` reports `done_total` equal to the last instruction's execute cycle plus 1. An end-only descriptor (`in_nop_end`=1) with no instruction in the program reports 0.
- R8: Closing a program clears every writer entry, so the first instruction of the next program executes at cycle 2, even if it reads a register written before.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output values hold steady and `in_ready` is 0. No descriptor is lost or reordered.
- R10: `sched_err` becomes 1 and stays 1 if an emitted instruction's decode cycle is at or before the execute cycle of its producer. On a correct schedule it stays 0.
- R11: Four independent instructions give a total of 6 cycles, and a four-instruction dependency chain gives 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| in_dst | input | 4 | Destination register index |
| in_src0 | input | 4 | First source register index |
| in_src0_en | input | 1 | First source is read |
| in_src1 | input | 4 | Second source register index |
| in_src1_en | input | 1 | Second source is read |
| in_last | input | 1 | This instruction closes the program |
| in_nop_end | input | 1 | End-only descriptor, carries no instruction, closes the program |
| out_valid | output | 1 | Instruction timestamps valid |
| out_ready | input | 1 | Consumer takes the output slot |
| out_fetch | output | 16 | Fetch cycle |
| out_decode | output | 16 | Decode cycle |
| out_exec | output | 16 | Execute cycle |
| done_valid | output | 1 | Program total valid (shares the output slot) |
| done_total | output | 16 | Total cycles of the closed program |
| sched_err | output | 1 | Sticky schedule-safety error |

## Verification
Assertions check several rules on every cycle. A stalled output holds its values. Each new execute cycle follows the previous one. A consumer lands at least two cycles after its producer. A fresh program starts at cycle 2 because the writer table really is empty. No emitted decode falls at or before its producer's execute. The bench's scenarios are the only evidence for other behaviour: which writer counts as the producer when a register is rewritten, that disabled sources are ignored, the totals for independent and chained programs, and the zero total of an empty program.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned DEF_REG_W = 4;
  localparam int unsigned DEF_CYC_W = 16;
  localparam int unsigned NUM_SRC   = 2;
  localparam int unsigned FIRST_EXEC = 2;
  localparam int unsigned RAW_GAP    = 2;
endpackage

// File: rtl/sched_scoreboard.sv
module sched_scoreboard
  import sched_pkg::*;
#(
  parameter int unsigned REG_W = DEF_REG_W,
  parameter int unsigned CYC_W = DEF_CYC_W,
  parameter int unsigned NRD   = NUM_SRC
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        wr_en,
  input  logic [REG_W-1:0]            wr_idx,
  input  logic [CYC_W-1:0]            wr_cyc,
  input  logic [NRD-1:0][REG_W-1:0]   rd_idx,
  output logic [NRD-1:0]              rd_hit,
  output logic [NRD-1:0][CYC_W-1:0]   rd_cyc
);
  localparam int unsigned NREG = 1 << REG_W;

  logic [NREG-1:0]  vld;
  logic [CYC_W-1:0] cyc_tab [NREG];

  // clear wins over the write of the closing instruction
  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) cyc_tab[wr_idx] <= wr_cyc;
  end

  // reads see the table before this cycle's write
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_hit[g] = vld[rd_idx[g]];
    assign rd_cyc[g] = cyc_tab[rd_idx[g]];
  end

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (vld == '0)); // R8
endmodule

// File: rtl/sched_timing.sv
module sched_timing
  import sched_pkg::*;
#(
  parameter int unsigned CYC_W = DEF_CYC_W,
  parameter int unsigned NSRC  = NUM_SRC
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  input  logic                        end_acc,
  input  logic [NSRC-1:0]             src_en,
  input  logic [NSRC-1:0]             hit,
  input  logic [NSRC-1:0][CYC_W-1:0]  prod_cyc,
  output logic [CYC_W-1:0]            exec_cyc,
  output logic [CYC_W-1:0]            total_now
);
  localparam int unsigned XW = CYC_W + 1;

  logic             fresh;
  logic [CYC_W-1:0] prev;
  logic [XW-1:0]    base;
  logic [XW-1:0]    cand [NSRC];
  logic [XW-1:0]    best;

  assign base = fresh ? XW'(FIRST_EXEC) : ({1'b0, prev} + XW'(1));

  for (genvar g = 0; g < NSRC; g++) begin : g_cand
    assign cand[g] = (src_en[g] && hit[g]) ? ({1'b0, prod_cyc[g]} + XW'(RAW_GAP)) : '0;
  end

  always_comb begin
    best = base;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] > best) best = cand[i];
    end
  end

  assign exec_cyc  = best[CYC_W-1:0];
  assign total_now = fresh ? '0 : (prev + CYC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh <= 1'b1;
      prev  <= '0;
    end else begin
      if (adv) prev <= exec_cyc;
      if (end_acc) fresh <= 1'b1;
      else if (adv) fresh <= 1'b0;
    end
  end

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (adv && !fresh) |-> (exec_cyc > prev)); // R4
  AST_FRESH_START: assert property (@(posedge clk) disable iff (rst)
    (adv && fresh) |-> (exec_cyc == CYC_W'(FIRST_EXEC))); // R8
  AST_RAW_GAP0: assert property (@(posedge clk) disable iff (rst)
    (adv && src_en[0] && hit[0]) |-> ({1'b0, exec_cyc} >= {1'b0, prod_cyc[0]} + XW'(RAW_GAP))); // R5
  AST_RAW_GAP1: assert property (@(posedge clk) disable iff (rst)
    (adv && src_en[1] && hit[1]) |-> ({1'b0, exec_cyc} >= {1'b0, prod_cyc[1]} + XW'(RAW_GAP))); // R5
endmodule

// File: rtl/sched_safety_mon.sv
module sched_safety_mon
  import sched_pkg::*;
#(
  parameter int unsigned REG_W = DEF_REG_W,
  parameter int unsigned CYC_W = DEF_CYC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              prog_end,
  input  logic [REG_W-1:0]  dst,
  input  logic [REG_W-1:0]  src0,
  input  logic              src0_en,
  input  logic [REG_W-1:0]  src1,
  input  logic              src1_en,
  input  logic [CYC_W-1:0]  decode,
  input  logic [CYC_W-1:0]  exec,
  output logic              err
);
  localparam int unsigned NREG = 1 << REG_W;

  logic [NREG-1:0]  pv;
  logic [CYC_W-1:0] pe [NREG];
  logic             bad0, bad1;

  assign bad0 = src0_en && pv[src0] && (decode <= pe[src0]);
  assign bad1 = src1_en && pv[src1] && (decode <= pe[src1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
      pv  <= '0;
    end else begin
      if (fire && (bad0 || bad1)) err <= 1'b1;
      if (prog_end) pv <= '0;
      else if (fire) pv[dst] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) pe[dst] <= exec;
  end

  AST_SAFE_SRC0: assert property (@(posedge clk) disable iff (rst)
    (fire && src0_en && pv[src0]) |-> (decode > pe[src0])); // R10
  AST_SAFE_SRC1: assert property (@(posedge clk) disable iff (rst)
    (fire && src1_en && pv[src1]) |-> (decode > pe[src1])); // R10
endmodule

// File: rtl/hazard_sched.sv
module hazard_sched
  import sched_pkg::*;
#(
  parameter int unsigned REG_W = DEF_REG_W,
  parameter int unsigned CYC_W = DEF_CYC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src0,
  input  logic              in_src0_en,
  input  logic [REG_W-1:0]  in_src1,
  input  logic              in_src1_en,
  input  logic              in_last,
  input  logic              in_nop_end,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CYC_W-1:0]  out_fetch,
  output logic [CYC_W-1:0]  out_decode,
  output logic [CYC_W-1:0]  out_exec,
  output logic              done_valid,
  output logic [CYC_W-1:0]  done_total,
  output logic              sched_err
);
  logic accept, adv, end_acc;
  logic [NUM_SRC-1:0]             src_en, hit;
  logic [NUM_SRC-1:0][REG_W-1:0]  src_idx;
  logic [NUM_SRC-1:0][CYC_W-1:0]  prod_cyc;
  logic [CYC_W-1:0]               exec_cyc, total_now;

  // output slot
  logic             slot_full, s_ins, s_end;
  logic [CYC_W-1:0] s_exec, s_total;
  logic [REG_W-1:0] s_dst, s_src0, s_src1;
  logic             s_src0_en, s_src1_en;

  assign in_ready = !slot_full || out_ready;
  assign accept   = in_valid && in_ready;
  assign adv      = accept && !in_nop_end;
  assign end_acc  = accept && (in_last || in_nop_end);

  assign src_idx = {in_src1, in_src0};
  assign src_en  = {in_src1_en, in_src0_en};

  sched_scoreboard #(.REG_W(REG_W), .CYC_W(CYC_W), .NRD(NUM_SRC)) i_sb (
    .clk    (clk),
    .rst    (rst),
    .clr    (end_acc),
    .wr_en  (adv),
    .wr_idx (in_dst),
    .wr_cyc (exec_cyc),
    .rd_idx (src_idx),
    .rd_hit (hit),
    .rd_cyc (prod_cyc)
  );

  sched_timing #(.CYC_W(CYC_W), .NSRC(NUM_SRC)) i_tim (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .end_acc   (end_acc),
    .src_en    (src_en),
    .hit       (hit),
    .prod_cyc  (prod_cyc),
    .exec_cyc  (exec_cyc),
    .total_now (total_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_full <= 1'b0;
      s_ins     <= 1'b0;
      s_end     <= 1'b0;
    end else if (accept) begin
      slot_full <= 1'b1;
      s_ins     <= !in_nop_end;
      s_end     <= in_last || in_nop_end;
    end else if (out_ready) begin
      slot_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s_exec    <= exec_cyc;
      s_total   <= in_nop_end ? total_now : (exec_cyc + CYC_W'(1));
      s_dst     <= in_dst;
      s_src0    <= in_src0;
      s_src0_en <= in_src0_en;
      s_src1    <= in_src1;
      s_src1_en <= in_src1_en;
    end
  end

  assign out_valid  = slot_full && s_ins;
  assign done_valid = slot_full && s_end;
  assign out_exec   = s_exec;
  assign out_decode = s_exec - CYC_W'(1);
  assign out_fetch  = s_exec - CYC_W'(2);
  assign done_total = s_total;

  sched_safety_mon #(.REG_W(REG_W), .CYC_W(CYC_W)) i_mon (
    .clk      (clk),
    .rst      (rst),
    .fire     (out_valid && out_ready),
    .prog_end (done_valid && out_ready),
    .dst      (s_dst),
    .src0     (s_src0),
    .src0_en  (s_src0_en),
    .src1     (s_src1),
    .src1_en  (s_src1_en),
    .decode   (out_decode),
    .exec     (out_exec),
    .err      (sched_err)
  );

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_exec))); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !out_ready) |=> (done_valid && $stable(done_total))); // R9
  AST_NO_TAKE_STALLED: assert property (@(posedge clk) disable iff (rst)
    (slot_full && !out_ready) |-> !in_ready); // R9
endmodule

// File: tb/test_hazard_sched.sv
module test_hazard_sched;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       in_valid = 1'b0, in_ready;
  logic [3:0] in_dst = '0, in_src0 = '0, in_src1 = '0;
  logic       in_src0_en = 1'b0, in_src1_en = 1'b0, in_last = 1'b0, in_nop_end = 1'b0;
  logic       out_valid, out_ready = 1'b0, done_valid, sched_err;
  logic [15:0] out_fetch, out_decode, out_exec, done_total;

  hazard_sched i_hazard_sched (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src0(in_src0), .in_src0_en(in_src0_en),
    .in_src1(in_src1), .in_src1_en(in_src1_en), .in_last(in_last),
    .in_nop_end(in_nop_end), .out_valid(out_valid), .out_ready(out_ready),
    .out_fetch(out_fetch), .out_decode(out_decode), .out_exec(out_exec),
    .done_valid(done_valid), .done_total(done_total), .sched_err(sched_err)
  );

  typedef struct packed {
    logic [3:0] dst; logic [3:0] s0; logic e0; logic [3:0] s1; logic e1;
    logic last; logic nop;
  } stim_t;

  stim_t st_q[$];
  string st_tag[$];
  int    st_want[$];

  int    ex_exec[$];
  string ex_tag[$];
  int    dn_total[$];
  string dn_tag[$];
  int    dn_want[$];

  // reference model state
  bit m_fresh = 1'b1;
  int m_prev = 0;
  bit m_v[16];
  int m_e[16];

  int checks = 0, errors = 0, cycles = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit hold_v = 1'b0;
  int hold_e = 0;
  bit hold_dv = 1'b0;
  int hold_t = 0;
  bit running = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic add(input int d, input int s0, input int e0, input int s1, input int e1,
                     input int last, input int nop, input string tag, input int want);
    stim_t s;
    s.dst = 4'(d); s.s0 = 4'(s0); s.e0 = 1'(e0); s.s1 = 4'(s1); s.e1 = 1'(e1);
    s.last = 1'(last); s.nop = 1'(nop);
    st_q.push_back(s); st_tag.push_back(tag); st_want.push_back(want);
  endtask

  task automatic model_clear();
    for (int r = 0; r < 16; r++) m_v[r] = 1'b0;
    m_fresh = 1'b1;
  endtask

  task automatic model_accept(input stim_t s, input string tag, input int want);
    int e;
    string t;
    if (s.nop) begin
      dn_total.push_back(m_fresh ? 0 : m_prev + 1);
      dn_tag.push_back(tag == "" ? "R7" : tag);
      dn_want.push_back(want);
      model_clear();
    end else begin
      e = m_fresh ? 2 : m_prev + 1;
      t = m_fresh ? "R2" : "R4";
      if (s.e0 && m_v[s.s0] && m_e[s.s0] + 2 > e) begin e = m_e[s.s0] + 2; t = "R5"; end
      if (s.e1 && m_v[s.s1] && m_e[s.s1] + 2 > e) begin e = m_e[s.s1] + 2; t = "R5"; end
      if (tag != "" && !s.last) t = tag;
      ex_exec.push_back(e); ex_tag.push_back(t);
      m_v[s.dst] = 1'b1; m_e[s.dst] = e;
      m_prev = e; m_fresh = 1'b0;
      if (s.last) begin
        dn_total.push_back(e + 1);
        dn_tag.push_back(tag == "" ? "R7" : tag);
        dn_want.push_back(want);
        model_clear();
      end
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      cycles++;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (lfsr[2:0] != 3'b000) && (lfsr[5:3] != 3'b111 || lfsr[0]);
      if (st_q.size() != 0 && lfsr[7:6] != 2'b00) begin
        in_valid = 1'b1;
        in_dst = st_q[0].dst; in_src0 = st_q[0].s0; in_src0_en = st_q[0].e0;
        in_src1 = st_q[0].s1; in_src1_en = st_q[0].e1;
        in_last = st_q[0].last; in_nop_end = st_q[0].nop;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      // R9: values held while stalled
      if (hold_v) begin
        chk(out_valid == 1'b1, "R9", int'(out_valid), 1);
        chk(int'(out_exec) == hold_e, "R9", int'(out_exec), hold_e);
      end
      if (hold_dv) begin
        chk(done_valid == 1'b1 && int'(done_total) == hold_t, "R9", int'(done_total), hold_t);
      end
      hold_v = out_valid && !out_ready;
      hold_e = int'(out_exec);
      hold_dv = done_valid && !out_ready;
      hold_t = int'(done_total);
      if ((out_valid || done_valid) && !out_ready)
        chk(in_ready == 1'b0, "R9", int'(in_ready), 0);
      chk(sched_err == 1'b0, "R10", int'(sched_err), 0);
      if (out_valid && out_ready) begin
        if (ex_exec.size() == 0) chk(1'b0, "R9", 1, 0);
        else begin
          int e; string t;
          e = ex_exec.pop_front(); t = ex_tag.pop_front();
          chk(int'(out_exec) == e, t, int'(out_exec), e);
          chk(int'(out_fetch) == e - 2, "R3", int'(out_fetch), e - 2);
          chk(int'(out_decode) == e - 1, "R3", int'(out_decode), e - 1);
        end
      end
      if (done_valid && out_ready) begin
        if (dn_total.size() == 0) chk(1'b0, "R7", 1, 0);
        else begin
          int tt, w; string t;
          tt = dn_total.pop_front(); t = dn_tag.pop_front(); w = dn_want.pop_front();
          chk(int'(done_total) == tt, t, int'(done_total), tt);
          if (w >= 0) chk(int'(done_total) == w, t, int'(done_total), w);
        end
      end
      if (in_valid && in_ready) begin
        stim_t s; string tg; int w;
        s = st_q.pop_front(); tg = st_tag.pop_front(); w = st_want.pop_front();
        model_accept(s, tg, w);
      end
    end
  end

  initial begin
    // P1: four independent instructions (R11)
    add(1,0,1,0,0,0,0,"",-1); add(2,0,1,0,0,0,0,"",-1);
    add(3,0,1,0,0,0,0,"",-1); add(4,0,1,0,0,1,0,"R11",6);
    // P2: four-instruction chain (R11)
    add(1,0,1,0,0,0,0,"",-1); add(2,1,1,0,0,0,0,"",-1);
    add(3,2,1,0,0,0,0,"",-1); add(4,3,1,0,0,1,0,"R11",9);
    // P3: stale producer, self-read, disabled sources, rewrite, end-only close
    add(7,4,1,3,1,0,0,"R8",-1);   // exec 2
    add(7,7,1,0,0,0,0,"R6",-1);   // exec 4
    add(8,7,0,7,0,0,0,"R5",-1);   // exec 5, sources disabled
    add(7,2,1,0,0,0,0,"R4",-1);   // exec 6
    add(9,0,0,7,1,0,0,"R6",-1);   // exec 8, newest writer of r7
    add(0,0,0,0,0,0,1,"R7",9);
    // P4: empty program
    add(0,0,0,0,0,0,1,"R7",0);
    // P5: longer random programs
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 25; i++)
        add($urandom_range(0,5), $urandom_range(0,5), $urandom_range(0,1),
            $urandom_range(0,5), $urandom_range(0,1), (i == 24 && p[0]) ? 1 : 0, 0, "", -1);
      if (!p[0]) add(0,0,0,0,0,0,1,"", -1);
    end

    repeat (3) @(posedge clk);
    #5;
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(done_valid == 1'b0, "R1", int'(done_valid), 0);
    chk(sched_err == 1'b0, "R1", int'(sched_err), 0);
    @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    while ((st_q.size() != 0 || ex_exec.size() != 0 || dn_total.size() != 0) && cycles < 100000)
      @(posedge clk);
    if (cycles >= 100000) chk(1'b0, "watchdog", cycles, 100000);
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule